// File: doc/BRIEF.md
# IRQ Exception Entry and Return Sequencer

This block captures the architectural state change a processor core performs when it accepts an IRQ exception, and the change it performs when it executes an exception-return instruction. Each cycle the core presents its current program counter, its packed processor-state word and its vector base address. The block also receives the level-sensitive IRQ line and an exception-return strobe. From these it produces the program counter and processor state the core must adopt on the next cycle. It also holds the banked return address, the banked processor state and a syndrome register.

Each cycle a decision stage picks one of three actions: `ACT_HOLD`, `ACT_ENTER` or `ACT_RETURN`. On `ACT_ENTER` the block sends the core to an exception vector. It masks all four exception mask bits, selects exception level 1 and selects the dedicated stack. At the same clock edge it banks the interrupted PC and state. On `ACT_RETURN` the banked values are handed back unchanged. A two-state frame machine tracks whether the banked registers hold a frame that has not yet been returned from. Its states are `FR_EMPTY` and `FR_LIVE`. The transition `FR_EMPTY -> FR_LIVE` occurs on entry, and `FR_LIVE -> FR_EMPTY` occurs on return. Entry while `FR_LIVE` and return while `FR_EMPTY` keep the current state.

The processor-state word is 7 bits wide: bit 6 D, bit 5 A, bit 4 I, bit 3 F, bits 2:1 exception level, bit 0 stack select.

Top module: `exc_seq_unit`

## Requirements
- R1: During and directly after reset, `elr_q`, `spsr_q` and `esr_q` are zero and `frame_live` is 0.
- R2: `take_irq` is 1 in a cycle exactly when `irq_lvl` is 1, `cur_pstate[4]` (I) is 0 and `eret_req` is 0.
- R3: In a cycle with `take_irq` high, `next_pstate` is 7'b1111_01_1 (0x7B): D, A, I and F set, level 01, stack select 1.
- R4: At the clock edge ending a cycle with `take_irq` high, `elr_q` takes the value of `cur_pc`.
- R5: At that same edge, `spsr_q` takes the value of `cur_pstate`.
- R6: An IRQ taken with `cur_pstate[2:1]` = 00 gives `next_pc` = `vbar` + 0x480.
- R7: An IRQ taken with `cur_pstate[2:1]` not 00 gives `next_pc` = `vbar` + 0x280 when `cur_pstate[0]` is 1, and `vbar` + 0x080 when it is 0.
- R8: When `eret_req` is 1, `next_pc` equals `elr_q`, `next_pstate` equals `spsr_q`, and the banked registers keep their values across that edge.
- R9: When `eret_req` and an unmasked `irq_lvl` are high in the same cycle, the return is performed, no IRQ is taken and nothing is banked. The IRQ is judged against the restored mask on a later cycle.
- R10: On entry, `esr_q` is loaded with the fixed placeholder syndrome 32'h0000_0001.
- R11: `frame_live` becomes 1 after an entry and 0 after a return.
- R12: In a cycle with neither entry nor return, `next_pc` equals `cur_pc`, `next_pstate` equals `cur_pstate`, and the banked registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl | input | 1 | Level-sensitive interrupt request |
| eret_req | input | 1 | Exception-return strobe for this cycle |
| cur_pc | input | PC_W | Current program counter |
| cur_pstate | input | 7 | Current processor state {D,A,I,F,EL[1:0],SPSel} |
| vbar | input | PC_W | Vector base address |
| next_pc | output | PC_W | Program counter for the next cycle |
| next_pstate | output | 7 | Processor state for the next cycle |
| take_irq | output | 1 | IRQ exception accepted this cycle |
| elr_q | output | PC_W | Banked return address |
| spsr_q | output | 7 | Banked processor state |
| esr_q | output | ESR_W | Syndrome register |
| frame_live | output | 1 | Banked frame not yet returned from |

## Verification
Exception entry and exception return can both be requested in the same cycle. The bench provokes this in two ways. In a directed step it raises `irq_lvl` with I clear in the same cycle as `eret_req`. In a long run it raises both lines at random, feeding each cycle's predicted next state back in as the current state. The reference model gives the return priority. It is judged on four points: `next_pc` and `next_pstate` must carry the banked values, `take_irq` must stay low, and the banked registers must be unchanged after the edge. In the following cycle the still-high IRQ must be accepted or refused according to the I bit that was just restored.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef struct packed {
        logic       d;
        logic       a;
        logic       i;
        logic       f;
        logic [1:0] el;
        logic       spsel;
    } pstate_t;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2
    } act_e;

    typedef enum logic {
        FR_EMPTY = 1'b0,
        FR_LIVE  = 1'b1
    } frame_e;

    localparam int PS_W = $bits(pstate_t);

    localparam pstate_t ENTRY_PS = '{d: 1'b1, a: 1'b1, i: 1'b1, f: 1'b1,
                                     el: 2'b01, spsel: 1'b1};

endpackage

// File: rtl/exc_decide.sv
module exc_decide
    import exc_seq_pkg::*;
(
    input  logic irq_lvl,
    input  logic eret_req,
    input  logic i_mask,
    output act_e act
);
    // Return has priority over a same-cycle interrupt.
    always_comb begin
        if (eret_req)
            act = ACT_RETURN;
        else if (irq_lvl && !i_mask)
            act = ACT_ENTER;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        assert (!(eret_req && act == ACT_ENTER)); // p_eret_first_r9
    end
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel #(
    parameter int PC_W          = 64,
    parameter int OFF_LOWER     = 'h480,
    parameter int OFF_CUR_SPX   = 'h280,
    parameter int OFF_CUR_SP0   = 'h080
) (
    input  logic [PC_W-1:0] vbar,
    input  logic [1:0]      src_el,
    input  logic            src_spsel,
    output logic [PC_W-1:0] vec_pc
);
    localparam logic [PC_W-1:0] L_LOWER = PC_W'(OFF_LOWER);
    localparam logic [PC_W-1:0] L_SPX   = PC_W'(OFF_CUR_SPX);
    localparam logic [PC_W-1:0] L_SP0   = PC_W'(OFF_CUR_SP0);

    logic [PC_W-1:0] off;

    always_comb begin
        if (src_el == 2'b00)
            off = L_LOWER;
        else if (src_spsel)
            off = L_SPX;
        else
            off = L_SP0;
        vec_pc = vbar + off;
    end
endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_seq_pkg::*;
#(
    parameter int              PC_W    = 64,
    parameter int              ESR_W   = 32,
    parameter logic [ESR_W-1:0] SYN_IRQ = ESR_W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_e             act,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PS_W-1:0]  cur_pstate,
    output logic [PC_W-1:0]  elr_q,
    output logic [PS_W-1:0]  spsr_q,
    output logic [ESR_W-1:0] esr_q,
    output logic             frame_live
);
    frame_e state_q, state_d;

    // Frame state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FR_EMPTY;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_EMPTY: if (act == ACT_ENTER)  state_d = FR_LIVE;
            FR_LIVE:  if (act == ACT_RETURN) state_d = FR_EMPTY;
            default:  state_d = FR_EMPTY;
        endcase
    end

    // Banked registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elr_q  <= '0;
            spsr_q <= '0;
            esr_q  <= '0;
        end else if (act == ACT_ENTER) begin
            elr_q  <= cur_pc;
            spsr_q <= cur_pstate;
            esr_q  <= SYN_IRQ;
        end
    end

    always_comb frame_live = (state_q == FR_LIVE);

    p_bank_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_ENTER |=> elr_q == $past(cur_pc));
    p_bank_ps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_ENTER |=> spsr_q == $past(cur_pstate));
    p_ret_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_RETURN |=> $stable(elr_q) && $stable(spsr_q));
    p_live_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_ENTER |=> frame_live);
    p_live_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_RETURN |=> !frame_live);
    p_syn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_ENTER |=> esr_q == SYN_IRQ);
endmodule

// File: rtl/exc_seq_unit.sv
module exc_seq_unit
    import exc_seq_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int ESR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_lvl,
    input  logic             eret_req,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [6:0]       cur_pstate,
    input  logic [PC_W-1:0]  vbar,
    output logic [PC_W-1:0]  next_pc,
    output logic [6:0]       next_pstate,
    output logic             take_irq,
    output logic [PC_W-1:0]  elr_q,
    output logic [6:0]       spsr_q,
    output logic [ESR_W-1:0] esr_q,
    output logic             frame_live
);
    pstate_t         ps;
    act_e            act;
    logic [PC_W-1:0] vec_pc;

    always_comb ps = pstate_t'(cur_pstate);

    exc_decide u_decide (
        .irq_lvl  (irq_lvl),
        .eret_req (eret_req),
        .i_mask   (ps.i),
        .act      (act)
    );

    exc_vec_sel #(.PC_W(PC_W)) u_vec (
        .vbar      (vbar),
        .src_el    (ps.el),
        .src_spsel (ps.spsel),
        .vec_pc    (vec_pc)
    );

    exc_bank #(.PC_W(PC_W), .ESR_W(ESR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .cur_pc     (cur_pc),
        .cur_pstate (cur_pstate),
        .elr_q      (elr_q),
        .spsr_q     (spsr_q),
        .esr_q      (esr_q),
        .frame_live (frame_live)
    );

    // Output selection
    always_comb begin
        take_irq = 1'b0;
        unique case (act)
            ACT_ENTER: begin
                take_irq    = 1'b1;
                next_pc     = vec_pc;
                next_pstate = ENTRY_PS;
            end
            ACT_RETURN: begin
                next_pc     = elr_q;
                next_pstate = spsr_q;
            end
            default: begin
                next_pc     = cur_pc;
                next_pstate = cur_pstate;
            end
        endcase
    end

    p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_pstate[4] |-> !take_irq);
    p_entry_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> next_pstate[6:3] == 4'hF && next_pstate[2:1] == 2'b01);
    p_ret_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eret_req |-> next_pc == elr_q && !take_irq);
endmodule

// File: tb/tb_exc_seq_unit.sv
`timescale 1ns/1ps
module tb_exc_seq_unit;
    localparam int PC_W = 64;
    localparam int ESR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_lvl = 1'b0, eret_req = 1'b0;
    logic [PC_W-1:0] cur_pc = '0, vbar = '0;
    logic [6:0] cur_pstate = '0;
    logic [PC_W-1:0] next_pc, elr_q;
    logic [6:0] next_pstate, spsr_q;
    logic take_irq, frame_live;
    logic [ESR_W-1:0] esr_q;

    int n_run = 0, n_fail = 0;

    // Reference model state
    logic [63:0] m_elr = '0;
    logic [6:0]  m_spsr = '0;
    logic [31:0] m_esr = '0;
    bit          m_live = 1'b0;
    logic [63:0] e_pc;
    logic [6:0]  e_ps;

    always #2 clk = ~clk;

    exc_seq_unit #(.PC_W(PC_W), .ESR_W(ESR_W)) dut (
        .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .eret_req(eret_req),
        .cur_pc(cur_pc), .cur_pstate(cur_pstate), .vbar(vbar),
        .next_pc(next_pc), .next_pstate(next_pstate), .take_irq(take_irq),
        .elr_q(elr_q), .spsr_q(spsr_q), .esr_q(esr_q), .frame_live(frame_live)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare, model update at posedge.
    task automatic step(input bit irq, input bit eret, input logic [63:0] pc,
                        input logic [6:0] ps, input logic [63:0] vb);
        bit tk, rt;
        logic [63:0] off;
        string rp, rs;
        irq_lvl = irq; eret_req = eret; cur_pc = pc; cur_pstate = ps; vbar = vb;
        rt = eret;
        tk = !eret && irq && !ps[4];
        if (rt) begin
            e_pc = m_elr; e_ps = m_spsr; rp = "R8"; rs = "R8";
        end else if (tk) begin
            if (ps[2:1] == 2'b00) begin off = 64'h480; rp = "R6"; end
            else if (ps[0])       begin off = 64'h280; rp = "R7"; end
            else                  begin off = 64'h080; rp = "R7"; end
            e_pc = vb + off; e_ps = 7'h7B; rs = "R3";
        end else begin
            e_pc = pc; e_ps = ps; rp = "R12"; rs = "R12";
        end
        #1;
        chk(next_pc == e_pc, rp, next_pc, e_pc);
        chk(next_pstate == e_ps, rs, 64'(next_pstate), 64'(e_ps));
        chk(take_irq == tk, (eret && irq) ? "R9" : "R2", 64'(take_irq), 64'(tk));
        chk(elr_q == m_elr, "R4", elr_q, m_elr);
        chk(spsr_q == m_spsr, "R5", 64'(spsr_q), 64'(m_spsr));
        chk(esr_q == m_esr, "R10", 64'(esr_q), 64'(m_esr));
        chk(frame_live == m_live, "R11", 64'(frame_live), 64'(m_live));
        @(posedge clk);
        if (rt) m_live = 1'b0;
        else if (tk) begin
            m_elr = pc; m_spsr = ps; m_esr = 32'h1; m_live = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] pc, vb;
        logic [6:0] ps;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(elr_q == '0, "R1", elr_q, 64'h0);
        chk(spsr_q == '0 && esr_q == '0, "R1", 64'({spsr_q, esr_q}), 64'h0);
        chk(frame_live == 1'b0, "R1", 64'(frame_live), 64'h0);
        rst_n = 1'b1;
        vb = 64'hFFFF_0000_0000_0800;
        // R6: from EL0, interrupts unmasked
        step(1, 0, 64'h0000_0000_0040_1234, 7'b0000_00_0, vb);
        // R2: level still high but I now set
        step(1, 0, e_pc, e_ps, vb);
        // R7: EL1, SPSel=1, I cleared
        step(1, 0, 64'h1111_2222_3333_4440, 7'b1101_01_1, vb);
        // R7: EL1, SPSel=0
        step(1, 0, 64'h0000_0000_0000_AAA0, 7'b0000_01_0, vb);
        // R8: return alone
        step(0, 1, 64'h5, 7'h7B, vb);
        // R12: idle with return already done
        step(0, 0, 64'h1234, 7'b0001_00_0, vb);
        // R9: enter then same-cycle return and IRQ
        step(1, 0, 64'h0000_0000_0000_9000, 7'b0000_00_0, vb);
        step(1, 1, e_pc, e_ps, vb);
        step(1, 0, e_pc, e_ps, vb); // R9: IRQ judged on restored mask
        // Random run with feedback of predicted state
        pc = 64'h8000; ps = 7'b0000_00_0;
        for (int k = 0; k < 400; k++) begin
            bit ir, er;
            ir = ($urandom % 3) == 0;
            er = ($urandom % 5) == 0;
            if (($urandom % 6) == 0) ps[4] = 1'b0;
            if (($urandom % 9) == 0) ps[0] = ~ps[0];
            if (($urandom % 7) == 0) vb = {$urandom, $urandom} & ~64'h7FF;
            step(ir, er, pc, ps, vb);
            pc = e_pc + (e_pc == pc ? 64'd4 : 64'd0);
            ps = e_ps;
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule